// File: doc/BRIEF.md
# DMA Channel Interrupt Status Bank

This block gathers completion and error events from a set of DMA channel engines into one interrupt line. It holds two 32-bit enable words and two 32-bit pending words. Each channel owns a 4-bit group of event types, and eight groups are packed into each word. A channel engine raises a one-cycle strobe on an event input, and that strobe sets the matching pending bit.

Software reaches the bank through a small register bus with a request, a write strobe, an address and write data. Read data comes back one cycle later. Pending bits are cleared by writing ones to them. Enables are plain read/write bits, so software enables or disables one channel's event with a read-modify-write. The interrupt output is a registered OR of every pending bit whose enable is set. The channel count is a parameter: 8, 12 or 16.

Top module: `dma_irq_bank`

## Requirements
- R1: Enable word 0 is at address 0x00, enable word 1 at 0x04, pending word 0 at 0x10 and pending word 1 at 0x14. Reads of any other address return 0, and writes to any other address change no state.
- R2: Event input bit `evt_i[4*n+k]` (channel n, event type k in 0..3) sets bit (n mod 8)*4+k of pending word n/8. The package-done event is type 1, so the package-done bits of a word are those in mask 0x22222222.
- R3: Writing to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears the whole word.
- R4: When an event strobe and a write-1-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: A pending bit is set by its event whether or not its enable is set. An enabled pending bit is needed to raise the interrupt.
- R6: `irq_o` is registered. In each cycle it equals the OR over both words of (pending AND enable), taken as those registers stood one clock earlier.
- R7: An enable word holds the value last written to its live bits and returns it on read. Writing one word changes no bit of the other enable word.
- R8: Bits of groups for channels at or above the channel count read 0 in both enable and pending words, and writes to them have no effect.
- R9: After reset all enable and pending bits are 0 and `irq_o` is 0.
- R10: A read request returns its data on `rdata_o` after the next clock edge. The value is the register contents before any write or event in that same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register bus access request |
| we_i | input | 1 | Write (1) or read (0) for the current request |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| evt_i | input | 4*NUM_CH | Event strobes, four per channel |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt, high while any enabled pending bit is set |

## Verification
A lost or stuck pending bit shows on the next read of its pending word. It also shows in `irq_o` one cycle after the enable is set, because the interrupt line follows the enabled pending bits with a single register of delay. A bit mapped to the wrong group, or a clear that reaches the wrong bit, shows as a mismatch against the arithmetic word/bit position in the very next read. A clear that wins over a same-cycle event shows as a missing bit in the read that follows that cycle. Dead groups above the channel count show at once as nonzero read data.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int GRP_W        = 4;
  localparam int GRP_PER_WORD = 8;
  localparam int WORD_W       = 32;
  localparam int MAX_WORDS    = 2;
  localparam int PKG_DONE_BIT = 1;

  localparam logic [7:0] OFF_EN0 = 8'h00;
  localparam logic [7:0] OFF_EN1 = 8'h04;
  localparam logic [7:0] OFF_PD0 = 8'h10;
  localparam logic [7:0] OFF_PD1 = 8'h14;

  // mask of the bits owned by the first `groups` channel groups of a word
  function automatic logic [WORD_W-1:0] live_mask(input int groups);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int g = 0; g < GRP_PER_WORD; g++)
      if (g < groups) m[g*GRP_W +: GRP_W] = '1;
    return m;
  endfunction

  function automatic int word_groups(input int num_ch, input int w);
    int r;
    r = num_ch - w * GRP_PER_WORD;
    if (r < 0) r = 0;
    if (r > GRP_PER_WORD) r = GRP_PER_WORD;
    return r;
  endfunction
endpackage

// File: rtl/dma_irq_word.sv
module dma_irq_word
  import dma_irq_pkg::*;
#(
  parameter int GROUPS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              pd_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] evt_i,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] pd_o,
  output logic              hit_o
);
  localparam logic [WORD_W-1:0] LIVE = live_mask(GROUPS);

  logic [WORD_W-1:0] en_q, pd_q, clr, pd_d;

  assign clr  = pd_we_i ? wdata_i : '0;
  // set after clear: a same-cycle event survives the clear
  assign pd_d = ((pd_q & ~clr) | evt_i) & LIVE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      pd_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i & LIVE;
      pd_q <= pd_d;
    end
  end

  assign en_o  = en_q;
  assign pd_o  = pd_q;
  assign hit_o = |(en_q & pd_q);
endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [MAX_WORDS-1:0][WORD_W-1:0] en_all_i,
  input  logic [MAX_WORDS-1:0][WORD_W-1:0] pd_all_i,
  output logic [WORD_W-1:0]                rdata_o
);
  logic [WORD_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if      (addr_i == ADDR_W'(OFF_EN0)) rd_d = en_all_i[0];
    else if (addr_i == ADDR_W'(OFF_EN1)) rd_d = en_all_i[1];
    else if (addr_i == ADDR_W'(OFF_PD0)) rd_d = pd_all_i[0];
    else if (addr_i == ADDR_W'(OFF_PD1)) rd_d = pd_all_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  logic [NUM_CH*GRP_W-1:0] evt_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic                    irq_o
);
  localparam int EVT_W = NUM_CH * GRP_W;
  localparam int PAD_W = MAX_WORDS * WORD_W;

  logic [PAD_W-1:0]                 evt_pad;
  logic [MAX_WORDS-1:0][WORD_W-1:0] en_all, pd_all;
  logic [MAX_WORDS-1:0]             hit;
  logic                             wr;

  always_comb begin
    evt_pad = '0;
    evt_pad[EVT_W-1:0] = evt_i;
  end

  assign wr = req_i & we_i;

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    localparam int GROUPS = word_groups(NUM_CH, w);
    localparam logic [7:0] EN_OFF = (w == 0) ? OFF_EN0 : OFF_EN1;
    localparam logic [7:0] PD_OFF = (w == 0) ? OFF_PD0 : OFF_PD1;
    if (GROUPS > 0) begin : g_live
      dma_irq_word #(.GROUPS(GROUPS)) word_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_we_i (wr && addr_i == ADDR_W'(EN_OFF)),
        .pd_we_i (wr && addr_i == ADDR_W'(PD_OFF)),
        .wdata_i (wdata_i),
        .evt_i   (evt_pad[w*WORD_W +: WORD_W]),
        .en_o    (en_all[w]),
        .pd_o    (pd_all[w]),
        .hit_o   (hit[w])
      );
    end else begin : g_dead
      assign en_all[w] = '0;
      assign pd_all[w] = '0;
      assign hit[w]    = 1'b0;
    end
  end

  dma_irq_rd_mux #(.ADDR_W(ADDR_W)) rd_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (req_i & ~we_i),
    .addr_i   (addr_i),
    .en_all_i (en_all),
    .pd_all_i (pd_all),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |hit;
  end
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             req_i,
  input logic                             we_i,
  input logic [ADDR_W-1:0]                addr_i,
  input logic [WORD_W-1:0]                wdata_i,
  input logic [NUM_CH*GRP_W-1:0]          evt_i,
  input logic                             irq_o,
  input logic [MAX_WORDS-1:0][WORD_W-1:0] en_all,
  input logic [MAX_WORDS-1:0][WORD_W-1:0] pd_all
);
  localparam int EVT_W = NUM_CH * GRP_W;
  localparam logic [MAX_WORDS*WORD_W-1:0] LIVE_ALL =
    {live_mask(word_groups(NUM_CH, 1)), live_mask(word_groups(NUM_CH, 0))};

  logic [MAX_WORDS*WORD_W-1:0] evt_pad;
  logic past_ok;

  always_comb begin
    evt_pad = '0;
    evt_pad[EVT_W-1:0] = evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R6
  assert_irq_lags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    irq_o == $past(|(en_all & pd_all)));

  // R8
  always_comb begin
    if (rst_ni) begin
      assert_dead_bits_R8: assert (((en_all | pd_all) & ~LIVE_ALL) == '0)
        else $error("dead group bit set");
    end
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_w
    localparam logic [7:0] PD_OFF = (w == 0) ? OFF_PD0 : OFF_PD1;

    // R2, R4, R5
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
      (pd_all[w] & $past(evt_pad[w*WORD_W +: WORD_W])) == $past(evt_pad[w*WORD_W +: WORD_W]));

    // R3
    assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
      (req_i && we_i && addr_i == ADDR_W'(PD_OFF) && evt_pad[w*WORD_W +: WORD_W] == '0)
      |=> (pd_all[w] & $past(wdata_i)) == '0);

    // R3
    assert_pd_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
      (!(req_i && we_i && addr_i == ADDR_W'(PD_OFF)) && evt_pad[w*WORD_W +: WORD_W] == '0)
      |=> $stable(pd_all[w]));
  end
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dma_irq_bank_tb_top.sv
`timescale 1ns/1ps
module dma_irq_bank_tb_top;
  localparam int NUM_CH = 12;
  localparam int EVT_W  = NUM_CH * 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [EVT_W-1:0]  evt = '0;
  logic [31:0]       rdata;
  logic              irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_irq_bank #(.NUM_CH(NUM_CH), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .evt_i(evt), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] live(input int w);
    logic [31:0] m;
    m = '0;
    for (int g = 0; g < 8; g++)
      if (w * 8 + g < NUM_CH) m[g*4 +: 4] = 4'hF;
    return m;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bg [2];
    logic [7:0] offs [4];
    offs[0] = 8'h00; offs[1] = 8'h04; offs[2] = 8'h10; offs[3] = 8'h14;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: reset state
    chk({31'b0, irq}, 32'h0, "R9 irq after reset");
    for (int i = 0; i < 4; i++) begin
      bus_rd(offs[i], v);
      chk(v, 32'h0, "R9 register after reset");
    end

    // R7, R8: enable words hold live bits only
    bg[0] = 32'h8888_8888 & live(0);
    bg[1] = 32'h8888_8888 & live(1);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, v);
    chk(v, live(1), "R8 dead enable bits read 0");
    bus_wr(8'h00, bg[0]);
    bus_wr(8'h04, bg[1]);
    bus_rd(8'h00, v);
    chk(v, bg[0], "R7 enable word 0 readback");
    bus_rd(8'h04, v);
    chk(v, bg[1], "R7 enable word 1 readback");

    // R2, R6, R3, R7: sweep every channel and event type
    for (int n = 0; n < NUM_CH; n++) begin
      for (int k = 0; k < 4; k++) begin
        int w, b;
        logic [7:0] eo, po, oo;
        logic [31:0] bit_m;
        w = n / 8; b = (n % 8) * 4 + k;
        eo = (w == 0) ? 8'h00 : 8'h04;
        po = (w == 0) ? 8'h10 : 8'h14;
        oo = (w == 0) ? 8'h04 : 8'h00;
        bit_m = 32'h1 << b;
        bus_rd(eo, v);
        bus_wr(eo, v | bit_m);
        bus_rd(eo, v);
        chk(v, bg[w] | bit_m, "R7 enable set by read-modify-write");
        bus_rd(oo, v);
        chk(v, bg[1-w], "R7 other enable word untouched");
        pulse(EVT_W'(1) << (n * 4 + k));
        chk({31'b0, irq}, 32'h0, "R6 irq one cycle behind pending");
        @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R6 irq raised by enabled pending");
        bus_rd(po, v);
        chk(v, bit_m, "R2 event sets mapped pending bit");
        bus_wr(po, bit_m);
        chk({31'b0, irq}, 32'h1, "R6 irq still high right after clear");
        @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R6 irq low after clear");
        bus_rd(po, v);
        chk(v, 32'h0, "R3 write one clears pending bit");
        bus_wr(eo, bg[w]);
      end
    end

    // R5: pending set without enables, no interrupt
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h04, 32'h0);
    pulse('1);
    bus_rd(8'h10, v);
    chk(v, live(0), "R5 pending word 0 set with enables off");
    bus_rd(8'h14, v);
    chk(v, live(1), "R5 pending word 1 set with enables off, R8 dead bits 0");
    chk({31'b0, irq}, 32'h0, "R5 irq low with enables off");

    // R2: package-done mask enables only type-1 events
    bus_wr(8'h04, 32'h2222_2222);
    @(negedge clk);
    chk({31'b0, irq}, 32'h1, "R2 package-done enable raises irq");

    // R3: write zero leaves pending, all-ones clears
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10, v);
    chk(v, live(0), "R3 write zero leaves pending");
    bus_wr(8'h10, 32'h5555_5555);
    bus_rd(8'h10, v);
    chk(v, live(0) & 32'hAAAA_AAAA, "R3 partial clear");
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h10, v);
    chk(v, 32'h0, "R3 all-ones clears word 0");
    bus_rd(8'h14, v);
    chk(v, 32'h0, "R3 all-ones clears word 1");
    chk({31'b0, irq}, 32'h0, "R6 irq low with nothing pending");

    // R4: set wins over same-cycle clear
    pulse(EVT_W'(32'hF));
    @(negedge clk); req = 1; we = 1; addr = 8'h10; wdata = 32'hF; evt = EVT_W'(32'h6);
    @(negedge clk); req = 0; we = 0; evt = '0;
    bus_rd(8'h10, v);
    chk(v, 32'h6, "R4 event wins over clear in same cycle");

    // R10: read returns pre-update value
    @(negedge clk); req = 1; we = 0; addr = 8'h10; evt = EVT_W'(32'h100);
    @(negedge clk); req = 0; evt = '0;
    chk(rdata, 32'h6, "R10 read sees state before same-cycle event");
    bus_rd(8'h10, v);
    chk(v, 32'h106, "R10 event visible on next read");

    // R1: unmapped addresses
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h08, v);
    chk(v, 32'h0, "R1 unmapped read 0x08");
    bus_rd(8'h20, v);
    chk(v, 32'h0, "R1 unmapped read 0x20");
    bus_rd(8'h00, v);
    chk(v, 32'h0, "R1 enable 0 unchanged by unmapped write");
    bus_rd(8'h04, v);
    chk(v, 32'h2222_2222 & live(1), "R1 enable 1 unchanged by unmapped write");
    bus_rd(8'h10, v);
    chk(v, 32'h106, "R1 pending 0 unchanged by unmapped write");

    done = 1;
    finish_run();
  end
endmodule